// File: doc/BRIEF.md
# Carry-Driven Line Coordinate Generator

This block turns a pair of endpoints into the ordered list of pixel coordinates along the straight segment between them. It uses no multiplier and no divider. For sloped segments, two fractional accumulators advance in parallel, one driven by the horizontal span and one by the vertical span. Each accumulator's carry-out moves its coordinate by one. A coordinate pair is emitted only in iterations where at least one axis moved.

Segments with no horizontal extent, or with no vertical extent, skip the accumulators. They take a direct single-axis path that emits one pixel per beat. Results leave on a valid/ready stream with a marker on the final pixel. A pixel-writing or clipping stage downstream consumes them.

A client presents both endpoints with a one-cycle start pulse while `done_o` is high. It then drains the stream until it accepts the beat carrying the last marker. At that point the block returns to idle and raises `done_o` again.

Top module: `lsp_line_stepper`

## Requirements
- R1: After reset `pix_valid_o` is 0 and `done_o` is 1.
- R2: If the second endpoint's x is below the first's (unsigned), the two endpoints are exchanged before stepping. When the x values are equal the given order is kept. The emitted x values are therefore non-decreasing.
- R3: The first beat of every segment carries the (possibly exchanged) first endpoint. `pix_last_o` is 1 only on the final beat, and that beat carries exactly the (possibly exchanged) second endpoint.
- R4: When both x values are equal, x is held and y moves by one per beat toward the second endpoint, giving |dy|+1 beats. Two identical endpoints give one beat with `pix_last_o`=1.
- R5: When both y values are equal and the x values differ, y is held and x rises by one per beat, giving dx+1 beats.
- R6: For the remaining segments, the halved spans hx=floor(dx/2) and hy=floor(|dy|/2) are added once per iteration to two accumulators of width COORD_W-1. Both accumulators start at zero.
  - A carry out of the x accumulator raises x by one.
  - A carry out of the y accumulator moves y by one toward the second endpoint (down when the second y is smaller).
  - A beat is produced only in iterations where x or y moved.
- R7: Sloped stepping ends at the first moving iteration in which either (hx≠0 and x equals the second x) or (hy≠0 and y equals the second y). That beat is replaced by the second endpoint with `pix_last_o`=1. If hx and hy are both zero, the segment is just the two endpoints.
- R8: While `pix_valid_o`=1 and `pix_ready_i`=0, the valid flag, coordinates and last marker stay unchanged.
- R9: A start pulse while `done_o`=0 is ignored, and the beat sequence of the segment in progress is unaffected.
- R10: In the cycle after the beat with `pix_last_o`=1 is accepted, `done_o` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Loads the endpoints when `done_o` is high |
| ax_i | input | COORD_W | First endpoint x |
| ay_i | input | COORD_W | First endpoint y |
| bx_i | input | COORD_W | Second endpoint x |
| by_i | input | COORD_W | Second endpoint y |
| done_o | output | 1 | Idle with no beat pending |
| pix_valid_o | output | 1 | Beat available |
| pix_ready_i | input | 1 | Consumer accepts the beat |
| pix_x_o | output | COORD_W | Beat x coordinate |
| pix_y_o | output | COORD_W | Beat y coordinate |
| pix_last_o | output | 1 | Final beat of the segment |

## Verification
The bench sweeps every end point of a 5-bit coordinate space from two origins, under pseudo-random back-pressure, and compares each accepted beat with an arithmetic model.

This sweep catches several classes of error:
- **Exchange rule:** a design that skipped the exchange for leftward segments would walk x the wrong way or never terminate.
- **Y direction:** one that ignored the sign of dy would move y away from the target.
- **Halving:** one that used unhalved spans would produce a different carry pattern and pixel set.
- **Degenerate spans:** one that ignored the cases where hx or hy is zero (such as dx=1 or |dy|=1) would hang or overshoot.

Directed cases cover the two single-axis paths, coincident endpoints and the two-endpoint degenerate slope. A start pulse is injected mid-segment; a design that accepted it would corrupt the remaining beats.

// File: rtl/lsp_pkg.sv
package lsp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_FIRST = 3'd1,
        ST_VERT  = 3'd2,
        ST_HORZ  = 3'd3,
        ST_DIAG  = 3'd4,
        ST_FINAL = 3'd5
    } lsp_state_e;

endpackage

// File: rtl/lsp_setup.sv
module lsp_setup #(
    parameter int COORD_W = 16
) (
    input  logic [COORD_W-1:0] ax_i,
    input  logic [COORD_W-1:0] ay_i,
    input  logic [COORD_W-1:0] bx_i,
    input  logic [COORD_W-1:0] by_i,
    output logic [COORD_W-1:0] x0_o,
    output logic [COORD_W-1:0] y0_o,
    output logic [COORD_W-1:0] x1_o,
    output logic [COORD_W-1:0] y1_o,
    output logic [COORD_W-2:0] hx_o,
    output logic [COORD_W-2:0] hy_o,
    output logic               ydn_o
);
    logic               swap;
    logic [COORD_W-1:0] span_x;
    logic [COORD_W-1:0] span_y;

    always_comb begin
        swap  = (bx_i < ax_i);
        x0_o  = swap ? bx_i : ax_i;
        y0_o  = swap ? by_i : ay_i;
        x1_o  = swap ? ax_i : bx_i;
        y1_o  = swap ? ay_i : by_i;
        span_x = x1_o - x0_o;
        ydn_o = (y1_o < y0_o);
        span_y = ydn_o ? (y0_o - y1_o) : (y1_o - y0_o);
        hx_o  = span_x[COORD_W-1:1];
        hy_o  = span_y[COORD_W-1:1];
    end
endmodule

// File: rtl/lsp_accum.sv
module lsp_accum #(
    parameter int ACC_W = 15
) (
    input  logic [ACC_W-1:0] acc_i,
    input  logic [ACC_W-1:0] inc_i,
    output logic [ACC_W-1:0] sum_o,
    output logic             carry_o
);
    logic [ACC_W:0] wide;

    always_comb begin
        wide    = {1'b0, acc_i} + {1'b0, inc_i};
        sum_o   = wide[ACC_W-1:0];
        carry_o = wide[ACC_W];
    end
endmodule

// File: rtl/lsp_beat_reg.sv
module lsp_beat_reg #(
    parameter int COORD_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic [COORD_W-1:0] x_i,
    input  logic [COORD_W-1:0] y_i,
    input  logic               last_i,
    input  logic               ready_i,
    output logic               valid_o,
    output logic [COORD_W-1:0] x_o,
    output logic [COORD_W-1:0] y_o,
    output logic               last_o,
    output logic               free_o
);
    typedef struct packed {
        logic               valid;
        logic [COORD_W-1:0] x;
        logic [COORD_W-1:0] y;
        logic               last;
    } beat_t;

    beat_t beat_d, beat_q;

    always_comb begin
        free_o = !beat_q.valid || ready_i;
        beat_d = beat_q;
        if (free_o) begin
            beat_d.valid = load_i;
            if (load_i) begin
                beat_d.x    = x_i;
                beat_d.y    = y_i;
                beat_d.last = last_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) beat_q <= '0;
        else        beat_q <= beat_d;
    end

    assign valid_o = beat_q.valid;
    assign x_o     = beat_q.x;
    assign y_o     = beat_q.y;
    assign last_o  = beat_q.last;

    // R8
    beat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_q.valid && !ready_i) |=> (beat_q.valid && $stable(beat_q.x)
                                        && $stable(beat_q.y) && $stable(beat_q.last)));
endmodule

// File: rtl/lsp_line_stepper.sv
module lsp_line_stepper
    import lsp_pkg::*;
#(
    parameter int COORD_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [COORD_W-1:0] ax_i,
    input  logic [COORD_W-1:0] ay_i,
    input  logic [COORD_W-1:0] bx_i,
    input  logic [COORD_W-1:0] by_i,
    output logic               done_o,
    output logic               pix_valid_o,
    input  logic               pix_ready_i,
    output logic [COORD_W-1:0] pix_x_o,
    output logic [COORD_W-1:0] pix_y_o,
    output logic               pix_last_o
);
    localparam int ACC_W = COORD_W - 1;

    typedef struct packed {
        lsp_state_e         st;
        logic [COORD_W-1:0] cx;
        logic [COORD_W-1:0] cy;
        logic [COORD_W-1:0] ex;
        logic [COORD_W-1:0] ey;
        logic [ACC_W-1:0]   hx;
        logic [ACC_W-1:0]   hy;
        logic [ACC_W-1:0]   ix;
        logic [ACC_W-1:0]   iy;
        logic               ydn;
    } core_t;

    core_t core_d, core_q;

    logic [COORD_W-1:0] s_x0, s_y0, s_x1, s_y1;
    logic [ACC_W-1:0]   s_hx, s_hy;
    logic               s_ydn;

    logic [ACC_W-1:0]   ix_nx, iy_nx;
    logic               car_x, car_y;

    logic               slot_free;
    logic               emit;
    logic [COORD_W-1:0] em_x, em_y;
    logic               em_last;
    logic [COORD_W-1:0] nx, ny;
    logic               moved, term;

    lsp_setup #(.COORD_W(COORD_W)) u_setup (
        .ax_i (ax_i), .ay_i (ay_i), .bx_i (bx_i), .by_i (by_i),
        .x0_o (s_x0), .y0_o (s_y0), .x1_o (s_x1), .y1_o (s_y1),
        .hx_o (s_hx), .hy_o (s_hy), .ydn_o (s_ydn)
    );

    lsp_accum #(.ACC_W(ACC_W)) u_acc_x (
        .acc_i (core_q.ix), .inc_i (core_q.hx), .sum_o (ix_nx), .carry_o (car_x)
    );

    lsp_accum #(.ACC_W(ACC_W)) u_acc_y (
        .acc_i (core_q.iy), .inc_i (core_q.hy), .sum_o (iy_nx), .carry_o (car_y)
    );

    lsp_beat_reg #(.COORD_W(COORD_W)) u_beat (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (emit),
        .x_i     (em_x),
        .y_i     (em_y),
        .last_i  (em_last),
        .ready_i (pix_ready_i),
        .valid_o (pix_valid_o),
        .x_o     (pix_x_o),
        .y_o     (pix_y_o),
        .last_o  (pix_last_o),
        .free_o  (slot_free)
    );

    assign done_o = (core_q.st == ST_IDLE) && !pix_valid_o;

    always_comb begin
        core_d  = core_q;
        emit    = 1'b0;
        em_x    = core_q.cx;
        em_y    = core_q.cy;
        em_last = 1'b0;
        nx      = core_q.cx + {{(COORD_W-1){1'b0}}, car_x};
        ny      = core_q.ydn ? (core_q.cy - {{(COORD_W-1){1'b0}}, car_y})
                             : (core_q.cy + {{(COORD_W-1){1'b0}}, car_y});
        moved   = car_x || car_y;
        term    = ((core_q.hx != '0) && (nx == core_q.ex)) ||
                  ((core_q.hy != '0) && (ny == core_q.ey));

        unique case (core_q.st)
            ST_IDLE: begin
                if (start_i && done_o) begin
                    core_d.st  = ST_FIRST;
                    core_d.cx  = s_x0;
                    core_d.cy  = s_y0;
                    core_d.ex  = s_x1;
                    core_d.ey  = s_y1;
                    core_d.hx  = s_hx;
                    core_d.hy  = s_hy;
                    core_d.ydn = s_ydn;
                    core_d.ix  = '0;
                    core_d.iy  = '0;
                end
            end
            ST_FIRST: begin
                if (slot_free) begin
                    emit    = 1'b1;
                    em_last = (core_q.cx == core_q.ex) && (core_q.cy == core_q.ey);
                    if (em_last)
                        core_d.st = ST_IDLE;
                    else if (core_q.cx == core_q.ex)
                        core_d.st = ST_VERT;
                    else if (core_q.cy == core_q.ey)
                        core_d.st = ST_HORZ;
                    else if ((core_q.hx == '0) && (core_q.hy == '0))
                        core_d.st = ST_FINAL;
                    else
                        core_d.st = ST_DIAG;
                end
            end
            ST_VERT: begin
                if (slot_free) begin
                    emit      = 1'b1;
                    em_y      = core_q.ydn ? (core_q.cy - 1'b1) : (core_q.cy + 1'b1);
                    em_last   = (em_y == core_q.ey);
                    core_d.cy = em_y;
                    if (em_last) core_d.st = ST_IDLE;
                end
            end
            ST_HORZ: begin
                if (slot_free) begin
                    emit      = 1'b1;
                    em_x      = core_q.cx + 1'b1;
                    em_last   = (em_x == core_q.ex);
                    core_d.cx = em_x;
                    if (em_last) core_d.st = ST_IDLE;
                end
            end
            ST_DIAG: begin
                if (slot_free) begin
                    core_d.ix = ix_nx;
                    core_d.iy = iy_nx;
                    core_d.cx = nx;
                    core_d.cy = ny;
                    if (moved) begin
                        emit = 1'b1;
                        if (term) begin
                            em_x      = core_q.ex;
                            em_y      = core_q.ey;
                            em_last   = 1'b1;
                            core_d.cx = core_q.ex;
                            core_d.cy = core_q.ey;
                            core_d.st = ST_IDLE;
                        end else begin
                            em_x = nx;
                            em_y = ny;
                        end
                    end
                end
            end
            ST_FINAL: begin
                if (slot_free) begin
                    emit      = 1'b1;
                    em_x      = core_q.ex;
                    em_y      = core_q.ey;
                    em_last   = 1'b1;
                    core_d.cx = core_q.ex;
                    core_d.cy = core_q.ey;
                    core_d.st = ST_IDLE;
                end
            end
            default: core_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_q    <= '0;
            core_q.st <= ST_IDLE;
        end else begin
            core_q    <= core_d;
        end
    end

    // R2
    x_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_q.st != ST_IDLE) |-> (core_q.cx <= core_q.ex));

    // R3
    last_is_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid_o && pix_last_o) |-> ((pix_x_o == core_q.ex) && (pix_y_o == core_q.ey)));

    // R4
    vert_x_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((core_q.st == ST_VERT) && pix_valid_o) |-> (pix_x_o == core_q.ex));

    // R5
    horz_y_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((core_q.st == ST_HORZ) && pix_valid_o) |-> (pix_y_o == core_q.ey));

    // R9
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((core_q.st != ST_IDLE) && start_i) |=> ($stable(core_q.ex) && $stable(core_q.ey)));

    // R10
    done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid_o && pix_ready_i && pix_last_o) |=> done_o);
endmodule

// File: tb/tb_lsp_line_stepper.sv
module tb_lsp_line_stepper;
    localparam int CW    = 5;
    localparam int AW    = CW - 1;
    localparam int LIMIT = 190000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [CW-1:0] ax = '0, ay = '0, bx = '0, by = '0;
    logic          done;
    logic          pvalid;
    logic          pready = 1'b0;
    logic [CW-1:0] px, py;
    logic          plast;

    int n_vec  = 0;
    int n_bad  = 0;
    int cycles = 0;
    logic [15:0] lfsr = 16'hACE1;

    typedef struct packed {
        logic [CW-1:0] x;
        logic [CW-1:0] y;
        logic          last;
    } beat_t;
    beat_t exp_q[$];

    always #4 clk = ~clk;

    lsp_line_stepper #(.COORD_W(CW)) dut (
        .clk (clk), .rst_n (rst_n), .start_i (start),
        .ax_i (ax), .ay_i (ay), .bx_i (bx), .by_i (by),
        .done_o (done), .pix_valid_o (pvalid), .pix_ready_i (pready),
        .pix_x_o (px), .pix_y_o (py), .pix_last_o (plast)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == LIMIT) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: act=%0d cycles exp<%0d", cycles, LIMIT);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    task automatic check(input string tag, input bit ok, input int act, input int expv);
        n_vec = n_vec + 1;
        if (!ok) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: act=%0h exp=%0h", tag, act, expv);
        end
    endtask

    // Arithmetic model of R2..R7
    task automatic build_expected(input int a, input int b, input int c, input int d);
        int x0, y0, x1, y1, sx, sy, hx, hy, ia, ib, cx, cy, step;
        bit up;
        exp_q.delete();
        if (c < a) begin x0 = c; y0 = d; x1 = a; y1 = b; end
        else       begin x0 = a; y0 = b; x1 = c; y1 = d; end
        sx = x1 - x0;
        up = (y1 >= y0);
        sy = up ? (y1 - y0) : (y0 - y1);
        step = up ? 1 : -1;
        if (sx == 0) begin                       // R4
            for (int k = 0; k <= sy; k++)
                exp_q.push_back('{x: x0[CW-1:0], y: CW'(y0 + k*step), last: (k == sy)});
        end else if (sy == 0) begin              // R5
            for (int k = 0; k <= sx; k++)
                exp_q.push_back('{x: CW'(x0 + k), y: y0[CW-1:0], last: (k == sx)});
        end else begin                           // R6 R7
            hx = sx / 2; hy = sy / 2;
            exp_q.push_back('{x: x0[CW-1:0], y: y0[CW-1:0], last: 1'b0});
            if (hx == 0 && hy == 0) begin
                exp_q.push_back('{x: x1[CW-1:0], y: y1[CW-1:0], last: 1'b1});
            end else begin
                ia = 0; ib = 0; cx = x0; cy = y0;
                for (int it = 0; it < 100000; it++) begin
                    bit mx, my;
                    ia = ia + hx; mx = (ia >= (1 << AW)); ia = ia % (1 << AW);
                    ib = ib + hy; my = (ib >= (1 << AW)); ib = ib % (1 << AW);
                    if (mx) cx = cx + 1;
                    if (my) cy = cy + step;
                    if (mx || my) begin
                        if ((hx != 0 && cx == x1) || (hy != 0 && cy == y1)) begin
                            exp_q.push_back('{x: x1[CW-1:0], y: y1[CW-1:0], last: 1'b1});
                            break;
                        end
                        exp_q.push_back('{x: CW'(cx), y: CW'(cy), last: 1'b0});
                    end
                end
            end
        end
    endtask

    task automatic run_line(input string tag, input int a, input int b, input int c,
                            input int d, input bit poke);
        int  guard;
        int  idx;
        bit  got_last;
        build_expected(a, b, c, d);
        guard = 0;
        while (!done && guard < 100) begin @(negedge clk); guard++; end
        ax = CW'(a); ay = CW'(b); bx = CW'(c); by = CW'(d);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        ax = ~ax; ay = ay + 3; bx = ~bx; by = by + 7;
        idx = 0; got_last = 1'b0; guard = 0;
        while (!got_last && guard < 4000) begin
            lfsr   = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            pready = lfsr[0] | lfsr[3];
            // R9: start pulse with other endpoints while busy
            if (poke && guard == 3) begin
                start = 1'b1; ax = 0; ay = 0; bx = 1; by = 1;
            end else begin
                start = 1'b0;
            end
            if (pvalid && pready) begin
                if (exp_q.size() == 0) begin
                    check({tag, " extra beat"}, 1'b0, {px, py}, 0);
                    got_last = 1'b1;
                end else begin
                    beat_t e;
                    e = exp_q.pop_front();
                    check(tag, (px == e.x) && (py == e.y) && (plast == e.last),
                          {idx, px, py, plast}, {idx, e.x, e.y, e.last});
                    if (plast) got_last = 1'b1;
                end
                idx++;
            end
            @(negedge clk);
            guard++;
        end
        start  = 1'b0;
        pready = 1'b0;
        check({tag, " missing beats"}, exp_q.size() == 0 && got_last, exp_q.size(), 0);
        // R10: done the cycle after last beat accepted
        check("R10 done after last", done == 1'b1, done, 1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        check("R1 valid in reset", pvalid == 1'b0, pvalid, 0);
        check("R1 done in reset", done == 1'b1, done, 1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 done after reset", done == 1'b1 && pvalid == 1'b0, {done, pvalid}, 2);

        run_line("R4 vertical up",   3,  7,  3, 20, 1'b0);
        run_line("R4 vertical down", 3, 20,  3,  7, 1'b0);
        run_line("R4 single point",  9,  9,  9,  9, 1'b0);
        run_line("R5 horizontal",    2,  4, 25,  4, 1'b0);
        run_line("R2 swapped horiz", 25, 4,  2,  4, 1'b0);
        run_line("R7 halves zero",   0,  0,  1,  1, 1'b0);
        run_line("R6 diagonal",      0,  0, 31, 31, 1'b0);
        run_line("R2 swapped diag", 31,  0,  0, 31, 1'b0);
        run_line("R3 steep",         4,  1,  6, 30, 1'b0);
        run_line("R9 busy start",    0, 31, 31,  2, 1'b1);

        // R6 R7 R2 R3 sweep from two origins
        for (int ex = 0; ex < 32; ex++)
            for (int ey = 0; ey < 32; ey++)
                run_line("R6 R7 sweep0", 0, 0, ex, ey, 1'b0);
        for (int ex = 0; ex < 32; ex++)
            for (int ey = 0; ey < 32; ey++)
                run_line("R6 R7 sweep1", 13, 20, ex, ey, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule